// File: doc/BRIEF.md
# Next-PC and Branch Resolution Unit

This unit decides where a 32-bit RISC core fetches next, for an architecture with exactly one branch delay slot. Each cycle it is shown the PC of the instruction being retired, a decoded control-flow kind, the two source register values, a 16-bit relative offset field and a 26-bit absolute jump index. It evaluates equality and sign conditions. It builds the relative, region-absolute or register target. For the linking kinds it produces the return address (PC+8, which skips the delay slot) and the register that receives it.

A two-state machine models the delay slot. In state `S_SEQ` (sequential) every retired instruction, taken branch or not, is followed by PC+4. A taken branch retired in `S_SEQ` takes transition `T_REDIRECT`, which latches its target and moves to `S_SLOT` (delay slot pending). The next retired instruction is the delay-slot instruction. It takes transition `T_RESUME`: the latched target is issued as the next PC and the machine returns to `S_SEQ`. A not-taken or non-control instruction in `S_SEQ` takes `T_STAY_SEQ`, and a cycle without `step_i` holds either state (`T_HOLD`). Reset forces `S_SEQ`.

Top module: `npc_unit`

## Requirements
- R1: After reset the unit is in the sequential state: a step with kind 0 (no control flow) gives next_pc_o = pc_i+4, taken_o = 0, link_we_o = 0, and a redirect pending when reset was asserted is discarded.
- R2: In the sequential state next_pc_o is pc_i+4 for every kind; after a step with taken_o = 1, the next stepped instruction (the delay slot) gets next_pc_o equal to the latched target.
- R3: Conditions are tested on pc-independent operands: kind 1 taken when rs_i = rt_i, kind 2 when rs_i != rt_i; kinds 3 and 7 when signed rs_i >= 0, kind 4 when > 0, kind 5 when <= 0, kinds 6 and 8 when < 0; kinds 9 to 12 are always taken.
- R4: For kinds 1 to 8 the target is pc_i + 4 + the sign-extended value {off_i, 2'b00}.
- R5: For kinds 9 and 10 the target is {pc_i[31:28], jidx_i, 2'b00}.
- R6: For kinds 11 and 12 the target is rs_i unchanged.
- R7: Kinds 7, 8 and 10 assert link_we_o with link_dst_o = 31; kind 12 asserts link_we_o with link_dst_o = rd_i; in both cases link_val_o = pc_i + 8.
- R8: Kinds 7 and 8 assert link_we_o whether or not the condition holds.
- R9: addr_err_o is 1 exactly when the kind is 11 or 12 and rs_i[1:0] != 0, and 0 for every other kind.
- R10: While the delay slot is pending, the kind presented is ignored: taken_o, link_we_o and addr_err_o stay 0.
- R11: A cycle with step_i = 0 leaves the state and the latched target unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | The presented instruction retires this cycle |
| kind_i | input | 4 | Control-flow kind: 0 none, 1 eq, 2 ne, 3 ge0, 4 gt0, 5 le0, 6 lt0, 7 ge0+link, 8 lt0+link, 9 jump, 10 jump+link, 11 reg jump, 12 reg jump+link |
| pc_i | input | 32 | Address of the presented instruction |
| rs_i | input | 32 | First register operand |
| rt_i | input | 32 | Second register operand |
| off_i | input | 16 | Relative word offset field |
| jidx_i | input | 26 | Absolute jump word index |
| rd_i | input | 5 | Link destination for kind 12 |
| next_pc_o | output | 32 | Address to fetch after this instruction |
| taken_o | output | 1 | Control transfer is taken |
| link_we_o | output | 1 | Write link value to register file |
| link_dst_o | output | 5 | Link destination register index |
| link_val_o | output | 32 | Return address (PC+8) |
| addr_err_o | output | 1 | Register target is not word aligned |

## Verification
taken_o, link_we_o, link_dst_o, link_val_o, addr_err_o and next_pc_o depend combinationally on the inputs and the state, so they are due in the same cycle as the stimulus. The redirected target only shows on next_pc_o after one clock edge with step_i high. The bench drives inputs on the falling edge, samples just before the next rising edge, and then steps. For the target it checks one step later, on the delay-slot instruction, and for hold behaviour it checks after several cycles without step_i.

// File: rtl/npc_pkg.sv
package npc_pkg;
    localparam int KIND_W = 4;

    typedef enum logic [KIND_W-1:0] {
        K_NONE   = 4'd0,
        K_BEQ    = 4'd1,
        K_BNE    = 4'd2,
        K_BGEZ   = 4'd3,
        K_BGTZ   = 4'd4,
        K_BLEZ   = 4'd5,
        K_BLTZ   = 4'd6,
        K_BGEZL  = 4'd7,
        K_BLTZL  = 4'd8,
        K_JABS   = 4'd9,
        K_JABSL  = 4'd10,
        K_JREG   = 4'd11,
        K_JREGL  = 4'd12
    } npc_kind_e;

    typedef enum logic {
        S_SEQ  = 1'b0,
        S_SLOT = 1'b1
    } npc_state_e;
endpackage

// File: rtl/npc_cond.sv
module npc_cond
    import npc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  npc_kind_e         kind,
    input  logic [XLEN-1:0]   rs,
    input  logic [XLEN-1:0]   rt,
    output logic              is_ctl,
    output logic              cond_ok
);
    logic neg, zero;
    assign neg  = rs[XLEN-1];
    assign zero = ~|rs;

    always_comb begin
        is_ctl  = 1'b1;
        cond_ok = 1'b0;
        unique case (kind)
            K_BEQ:                      cond_ok = (rs == rt);
            K_BNE:                      cond_ok = (rs != rt);
            K_BGEZ, K_BGEZL:            cond_ok = !neg;
            K_BGTZ:                     cond_ok = !neg && !zero;
            K_BLEZ:                     cond_ok = neg || zero;
            K_BLTZ, K_BLTZL:            cond_ok = neg;
            K_JABS, K_JABSL,
            K_JREG, K_JREGL:            cond_ok = 1'b1;
            default: begin
                is_ctl  = 1'b0;
                cond_ok = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/npc_target.sv
module npc_target
    import npc_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int OFF_W  = 16,
    parameter int JIDX_W = 26
) (
    input  npc_kind_e          kind,
    input  logic [XLEN-1:0]    pc,
    input  logic [XLEN-1:0]    rs,
    input  logic [OFF_W-1:0]   off,
    input  logic [JIDX_W-1:0]  jidx,
    output logic [XLEN-1:0]    target,
    output logic               addr_err
);
    localparam int EXT_W = XLEN - OFF_W - 2;
    localparam int REG_W = XLEN - JIDX_W - 2;

    logic [XLEN-1:0] slot_pc, rel_off, rel_tgt, abs_tgt;

    assign slot_pc = pc + XLEN'(4);
    assign rel_off = {{EXT_W{off[OFF_W-1]}}, off, 2'b00};
    assign rel_tgt = slot_pc + rel_off;

    generate
        if (REG_W > 0) begin : g_region
            assign abs_tgt = {pc[XLEN-1 -: REG_W], jidx, 2'b00};
        end else begin : g_flat
            assign abs_tgt = XLEN'({jidx, 2'b00});
        end
    endgenerate

    always_comb begin
        target   = slot_pc;
        addr_err = 1'b0;
        unique case (kind)
            K_BEQ, K_BNE, K_BGEZ, K_BGTZ,
            K_BLEZ, K_BLTZ, K_BGEZL, K_BLTZL: target = rel_tgt;
            K_JABS, K_JABSL:                  target = abs_tgt;
            K_JREG, K_JREGL: begin
                target   = rs;
                addr_err = |rs[1:0];
            end
            default:                          target = slot_pc;
        endcase
    end
endmodule

// File: rtl/npc_link.sv
module npc_link
    import npc_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int REGIDX_W = 5,
    parameter int RA_IDX   = 31
) (
    input  npc_kind_e            kind,
    input  logic [XLEN-1:0]      pc,
    input  logic [REGIDX_W-1:0]  rd,
    output logic                 link_we,
    output logic [REGIDX_W-1:0]  link_dst,
    output logic [XLEN-1:0]      link_val
);
    assign link_val = pc + XLEN'(8);

    always_comb begin
        link_we  = 1'b0;
        link_dst = REGIDX_W'(RA_IDX);
        unique case (kind)
            K_BGEZL, K_BLTZL, K_JABSL: link_we = 1'b1;
            K_JREGL: begin
                link_we  = 1'b1;
                link_dst = rd;
            end
            default: link_we = 1'b0;
        endcase
    end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int OFF_W    = 16,
    parameter int JIDX_W   = 26,
    parameter int REGIDX_W = 5,
    parameter int RA_IDX   = 31
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step_i,
    input  logic [3:0]           kind_i,
    input  logic [XLEN-1:0]      pc_i,
    input  logic [XLEN-1:0]      rs_i,
    input  logic [XLEN-1:0]      rt_i,
    input  logic [OFF_W-1:0]     off_i,
    input  logic [JIDX_W-1:0]    jidx_i,
    input  logic [REGIDX_W-1:0]  rd_i,
    output logic [XLEN-1:0]      next_pc_o,
    output logic                 taken_o,
    output logic                 link_we_o,
    output logic [REGIDX_W-1:0]  link_dst_o,
    output logic [XLEN-1:0]      link_val_o,
    output logic                 addr_err_o
);
    npc_kind_e       kind;
    npc_state_e      state_q, state_d;
    logic [XLEN-1:0] tgt_q, tgt_w;
    logic            is_ctl, cond_ok, err_w, lk_we;
    logic            slot_w;

    assign kind   = npc_kind_e'(kind_i);
    assign slot_w = (state_q == S_SLOT);

    npc_cond #(.XLEN(XLEN)) u_cond (
        .kind    (kind),
        .rs      (rs_i),
        .rt      (rt_i),
        .is_ctl  (is_ctl),
        .cond_ok (cond_ok)
    );

    npc_target #(.XLEN(XLEN), .OFF_W(OFF_W), .JIDX_W(JIDX_W)) u_target (
        .kind     (kind),
        .pc       (pc_i),
        .rs       (rs_i),
        .off      (off_i),
        .jidx     (jidx_i),
        .target   (tgt_w),
        .addr_err (err_w)
    );

    npc_link #(.XLEN(XLEN), .REGIDX_W(REGIDX_W), .RA_IDX(RA_IDX)) u_link (
        .kind     (kind),
        .pc       (pc_i),
        .rd       (rd_i),
        .link_we  (lk_we),
        .link_dst (link_dst_o),
        .link_val (link_val_o)
    );

    // Transitions: T_REDIRECT, T_STAY_SEQ, T_RESUME, T_HOLD
    always_comb begin
        state_d = state_q;
        if (step_i) begin
            unique case (state_q)
                S_SEQ:  state_d = (is_ctl && cond_ok) ? S_SLOT : S_SEQ;
                S_SLOT: state_d = S_SEQ;
                default: state_d = S_SEQ;
            endcase
        end
    end

    // State register and latched redirect target
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_SEQ;
            tgt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (step_i && state_q == S_SEQ && is_ctl && cond_ok) begin
                tgt_q <= tgt_w;
            end
        end
    end

    // Outputs per state
    always_comb begin
        next_pc_o  = pc_i + XLEN'(4);
        taken_o    = 1'b0;
        link_we_o  = 1'b0;
        addr_err_o = 1'b0;
        unique case (state_q)
            S_SEQ: begin
                taken_o    = is_ctl && cond_ok;
                link_we_o  = lk_we;
                addr_err_o = err_w;
            end
            S_SLOT: begin
                next_pc_o  = tgt_q;
            end
            default: next_pc_o = pc_i + XLEN'(4);
        endcase
    end
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk
    import npc_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int REGIDX_W = 5,
    parameter int RA_IDX   = 31
) (
    input logic                clk,
    input logic                rst_n,
    input logic                step_i,
    input logic [3:0]          kind_i,
    input logic                taken_o,
    input logic                link_we_o,
    input logic [REGIDX_W-1:0] link_dst_o,
    input logic                addr_err_o,
    input logic                slot_w
);
    a_r2_slot_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && taken_o) |=> slot_w);

    a_r2_slot_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_w && step_i) |=> !slot_w);

    a_r10_slot_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        slot_w |-> (!taken_o && !link_we_o && !addr_err_o));

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(slot_w));

    a_r7_ra_dst: assert property (@(posedge clk) disable iff (!rst_n)
        (link_we_o && kind_i != K_JREGL) |-> (link_dst_o == REGIDX_W'(RA_IDX)));

    a_r9_err_kind: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err_o |-> (kind_i == K_JREG || kind_i == K_JREGL));
endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN), .REGIDX_W(REGIDX_W), .RA_IDX(RA_IDX)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_i     (step_i),
    .kind_i     (kind_i),
    .taken_o    (taken_o),
    .link_we_o  (link_we_o),
    .link_dst_o (link_dst_o),
    .addr_err_o (addr_err_o),
    .slot_w     (slot_w)
);

// File: tb/npc_unit_tb_top.sv
module npc_unit_tb_top;
    localparam int NV = 17;
    localparam int VW = 148;

    // kind[147:144] pc[143:112] rs[111:80] rt[79:48] off[47:32] jidx[31:6] rd[5:1] exp_taken[0]
    localparam logic [VW-1:0] VEC [0:NV-1] = '{
        {4'd1,  32'h0040_0000, 32'h0000_0005, 32'h0000_0005, 16'h0010, 26'h0, 5'd0, 1'b1},
        {4'd1,  32'h0040_0100, 32'h0000_0005, 32'h0000_0006, 16'h0010, 26'h0, 5'd0, 1'b0},
        {4'd2,  32'h0040_0200, 32'h0000_0005, 32'h0000_0006, 16'hFFFF, 26'h0, 5'd0, 1'b1},
        {4'd3,  32'h0040_0300, 32'h0000_0000, 32'h0,         16'h0004, 26'h0, 5'd0, 1'b1},
        {4'd3,  32'h0040_0400, 32'h8000_0000, 32'h0,         16'h0004, 26'h0, 5'd0, 1'b0},
        {4'd4,  32'h0040_0500, 32'h0000_0000, 32'h0,         16'h0008, 26'h0, 5'd0, 1'b0},
        {4'd4,  32'h0040_0600, 32'h0000_0001, 32'h0,         16'h8000, 26'h0, 5'd0, 1'b1},
        {4'd5,  32'h0040_0700, 32'h0000_0000, 32'h0,         16'h7FFF, 26'h0, 5'd0, 1'b1},
        {4'd5,  32'h0040_0800, 32'h7FFF_FFFF, 32'h0,         16'h0004, 26'h0, 5'd0, 1'b0},
        {4'd6,  32'h0040_0900, 32'hFFFF_FFFF, 32'h0,         16'hFFF0, 26'h0, 5'd0, 1'b1},
        {4'd7,  32'h0040_0A00, 32'h8000_0000, 32'h0,         16'h0020, 26'h0, 5'd0, 1'b0},
        {4'd8,  32'h0040_0B00, 32'h8000_0000, 32'h0,         16'h0020, 26'h0, 5'd0, 1'b1},
        {4'd9,  32'hA000_1000, 32'h0,         32'h0,         16'h0,    26'h3FF_FFFF, 5'd0, 1'b1},
        {4'd10, 32'h1000_0000, 32'h0,         32'h0,         16'h0,    26'h000_0010, 5'd0, 1'b1},
        {4'd11, 32'h0040_0C00, 32'h0040_1230, 32'h0,         16'h0,    26'h0, 5'd0, 1'b1},
        {4'd12, 32'h0040_0D00, 32'h0040_0002, 32'h0,         16'h0,    26'h0, 5'd7, 1'b1},
        {4'd0,  32'h0040_0E00, 32'h0000_0005, 32'h0000_0005, 16'h0010, 26'h0, 5'd0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_i = 1'b0;
    logic [3:0]  kind_i = 4'd0;
    logic [31:0] pc_i = '0, rs_i = '0, rt_i = '0;
    logic [15:0] off_i = '0;
    logic [25:0] jidx_i = '0;
    logic [4:0]  rd_i = '0;
    logic [31:0] next_pc_o, link_val_o;
    logic        taken_o, link_we_o, addr_err_o;
    logic [4:0]  link_dst_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    npc_unit dut_i (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .kind_i(kind_i),
        .pc_i(pc_i), .rs_i(rs_i), .rt_i(rt_i), .off_i(off_i),
        .jidx_i(jidx_i), .rd_i(rd_i), .next_pc_o(next_pc_o),
        .taken_o(taken_o), .link_we_o(link_we_o), .link_dst_o(link_dst_o),
        .link_val_o(link_val_o), .addr_err_o(addr_err_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_target(input logic [3:0] k, input logic [31:0] pc,
                                               input logic [31:0] rs, input logic [15:0] off,
                                               input logic [25:0] ji);
        logic [31:0] sx;
        sx = {{14{off[15]}}, off, 2'b00};
        if (k >= 4'd1 && k <= 4'd8)       return pc + 32'd4 + sx;
        else if (k == 4'd9 || k == 4'd10) return {pc[31:28], ji, 2'b00};
        else                              return rs;
    endfunction

    task automatic drive(input logic [3:0] k, input logic [31:0] pc, input logic [31:0] rs,
                         input logic [31:0] rt, input logic [15:0] off,
                         input logic [25:0] ji, input logic [4:0] rd);
        kind_i = k; pc_i = pc; rs_i = rs; rt_i = rt; off_i = off; jidx_i = ji; rd_i = rd;
    endtask

    task automatic step_once();
        step_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        step_i = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] tgt;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        drive(4'd0, 32'h0000_1000, 32'h0, 32'h0, 16'h0, 26'h0, 5'd0);
        #8;
        chk("R1 next_pc", next_pc_o, 32'h0000_1004);
        chk("R1 taken", {31'b0, taken_o}, 32'd0);
        chk("R1 link_we", {31'b0, link_we_o}, 32'd0);
        @(negedge clk);

        // Table walk: R2..R9, R10 on each delay slot
        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            logic [3:0] k;
            logic exp_lw;
            logic [4:0] exp_dst;
            logic exp_err;
            v = VEC[i];
            k = v[147:144];
            drive(k, v[143:112], v[111:80], v[79:48], v[47:32], v[31:6], v[5:1]);
            exp_lw  = (k == 4'd7 || k == 4'd8 || k == 4'd10 || k == 4'd12);
            exp_dst = (k == 4'd12) ? v[5:1] : 5'd31;
            exp_err = (k == 4'd11 || k == 4'd12) && (v[81:80] != 2'b00);
            tgt = ref_target(k, v[143:112], v[111:80], v[47:32], v[31:6]);
            #8;
            chk("R2 seq next_pc", next_pc_o, v[143:112] + 32'd4);
            chk("R3 taken", {31'b0, taken_o}, {31'b0, v[0]});
            chk("R7 R8 link_we", {31'b0, link_we_o}, {31'b0, exp_lw});
            if (exp_lw) begin
                chk("R7 link_dst", {27'b0, link_dst_o}, {27'b0, exp_dst});
                chk("R7 link_val", link_val_o, v[143:112] + 32'd8);
            end
            chk("R9 addr_err", {31'b0, addr_err_o}, {31'b0, exp_err});
            step_once();
            if (v[0]) begin
                // delay slot carrying a would-be-taken branch
                drive(4'd1, v[143:112] + 32'd4, 32'h0, 32'h0, 16'h0040, 26'h0, 5'd0);
                #8;
                chk("R4 R5 R6 target", next_pc_o, tgt);
                chk("R10 slot taken", {31'b0, taken_o}, 32'd0);
                chk("R10 slot link_we", {31'b0, link_we_o}, 32'd0);
                step_once();
            end
        end

        // R11: hold with no step
        drive(4'd1, 32'h0000_2000, 32'h1, 32'h1, 16'h0100, 26'h0, 5'd0);
        step_once();
        drive(4'd8, 32'h0000_2004, 32'hFFFF_FFFF, 32'h0, 16'h0, 26'h0, 5'd0);
        repeat (4) @(negedge clk);
        #8;
        chk("R11 held target", next_pc_o, 32'h0000_2404);
        chk("R11 held slot link_we", {31'b0, link_we_o}, 32'd0);
        step_once();
        drive(4'd0, 32'h0000_2404, 32'h0, 32'h0, 16'h0, 26'h0, 5'd0);
        #8;
        chk("R11 back to seq", next_pc_o, 32'h0000_2408);
        @(negedge clk);

        // R1: reset drops a pending redirect
        drive(4'd11, 32'h0000_3000, 32'h0000_8000, 32'h0, 16'h0, 26'h0, 5'd0);
        step_once();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        drive(4'd1, 32'h0000_3004, 32'h3, 32'h3, 16'h0001, 26'h0, 5'd0);
        #8;
        chk("R1 pending dropped", next_pc_o, 32'h0000_3008);
        chk("R1 seq after reset taken", {31'b0, taken_o}, 32'd1);
        step_once();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule